// File: doc/BRIEF.md
# Parallel Slave Bus Port

This block lets an external microprocessor exchange single bytes with on-chip logic over an 8-bit parallel bus. The host side has three asynchronous active-low strobes (select, read, write) and a data bus. The bus is split into an input, an output and an output-enable so that a pad cell can be placed outside the block. The local side has a mode enable, a one-cycle byte write into the output latch and a one-cycle byte read of the captured input byte. It also has an interrupt-clear pulse and four status flags.

Each strobe passes through a two-flop synchronizer. A small state machine then detects the start and end of each host access. When a host write ends, the byte on the bus is captured and flags are raised. While a host read lasts, the output latch is driven onto the bus. A host access that pulls read and write low together under select is refused as invalid.

Top module: `pbus_slave_port`

## Requirements
- R1: After reset, inFull, outFull, portIrq and overflow are 0 and hostDataOe is 0.
- R2: While portEnable is 0, the host strobes are ignored: hostDataOe stays 0 and no flag or latch changes.
- R3: A host write starts when select and write are both sampled low. It ends when either is sampled high. At the end, the byte on hostDataIn is captured into localRdData, and inFull and portIrq are set.
- R4: During a host read (select and read sampled low), hostDataOe is 1 and hostDataOut carries the output latch.
- R5: When select or read is sampled high after a host read, hostDataOe returns to 0, portIrq is set and outFull is cleared.
- R6: A localWrEn pulse loads localWrData into the output latch and sets outFull.
- R7: A localRdEn pulse clears inFull. localRdData keeps presenting the last captured byte.
- R8: If a host write ends while inFull is already 1, overflow is set. Overflow stays set until reset, and local reads do not clear it.
- R9: portIrq stays set until an irqClr pulse. A set and a clear in the same cycle leave it set.
- R10: If select, read and write are all sampled low together, the bus is not driven and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| portEnable | input | 1 | Enables response to the host bus |
| hostCsN | input | 1 | Host select, active low, asynchronous |
| hostRdN | input | 1 | Host read strobe, active low, asynchronous |
| hostWrN | input | 1 | Host write strobe, active low, asynchronous |
| hostDataIn | input | 8 | Byte from the host bus |
| hostDataOut | output | 8 | Byte driven to the host bus |
| hostDataOe | output | 1 | Output enable for the host bus |
| localWrEn | input | 1 | Load output latch pulse |
| localWrData | input | 8 | Byte for the output latch |
| localRdEn | input | 1 | Consume captured byte pulse |
| localRdData | output | 8 | Captured host byte |
| irqClr | input | 1 | Clears portIrq |
| inFull | output | 1 | Captured byte not yet consumed |
| outFull | output | 1 | Output byte not yet read by the host |
| portIrq | output | 1 | Access-complete interrupt flag |
| overflow | output | 1 | Sticky lost-byte flag |

## Verification
The overflow condition is the hardest case to reach. It needs a second complete host write to finish while the first byte is still unconsumed, with no local read in between. The stimulus issues two host writes back to back and holds localRdEn low between them. It then checks that overflow is set, that the newer byte replaced the older one, and that a later local read leaves overflow set. The invalid case is reached by pulling all three strobes low at once. The bench then confirms that no flag moved and that the bus was never driven.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WRITE   = 2'd1,
    ST_READ    = 2'd2,
    ST_INVALID = 2'd3
  } pbusState_t;

  typedef struct packed {
    logic captureIn;
    logic readDone;
    logic driveBus;
  } pbusStrobes_t;

endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '1;
        else       chain[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '1;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
  import pbus_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         portEnable,
  input  logic         csSyncN,
  input  logic         rdSyncN,
  input  logic         wrSyncN,
  output pbusStrobes_t strobes
);
  pbusState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobes   = '0;
    case (state)
      ST_IDLE: begin
        if (portEnable && !csSyncN) begin
          if (!rdSyncN && !wrSyncN) nextState = ST_INVALID;
          else if (!wrSyncN)        nextState = ST_WRITE;
          else if (!rdSyncN)        nextState = ST_READ;
        end
      end
      ST_WRITE: begin
        if (!portEnable) begin
          nextState = ST_IDLE;
        end else if (csSyncN || wrSyncN) begin
          strobes.captureIn = 1'b1;
          nextState         = ST_IDLE;
        end
      end
      ST_READ: begin
        strobes.driveBus = portEnable;
        if (!portEnable) begin
          nextState = ST_IDLE;
        end else if (csSyncN || rdSyncN) begin
          strobes.readDone = 1'b1;
          nextState        = ST_IDLE;
        end
      end
      ST_INVALID: begin
        if (!portEnable || csSyncN || (rdSyncN && wrSyncN)) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/pbus_datapath.sv
module pbus_datapath
  import pbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pbusStrobes_t      strobes,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  input  logic              localWrEn,
  input  logic [DATA_W-1:0] localWrData,
  input  logic              localRdEn,
  output logic [DATA_W-1:0] localRdData,
  input  logic              irqClr,
  output logic              inFull,
  output logic              outFull,
  output logic              portIrq,
  output logic              overflow
);
  logic [DATA_W-1:0] inLatch, outLatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inLatch  <= '0;
      inFull   <= 1'b0;
      overflow <= 1'b0;
    end else if (strobes.captureIn) begin
      inLatch <= hostDataIn;
      inFull  <= 1'b1;
      if (inFull) overflow <= 1'b1;
    end else if (localRdEn) begin
      inFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outLatch <= '0;
      outFull  <= 1'b0;
    end else if (localWrEn) begin
      outLatch <= localWrData;
      outFull  <= 1'b1;
    end else if (strobes.readDone) begin
      outFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                    portIrq <= 1'b0;
    else if (strobes.captureIn || strobes.readDone) portIrq <= 1'b1;
    else if (irqClr)                              portIrq <= 1'b0;
  end

  assign localRdData = inLatch;
  assign hostDataOut = outLatch;
  assign hostDataOe  = strobes.driveBus;
endmodule

// File: rtl/pbus_slave_port.sv
module pbus_slave_port
  import pbus_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEnable,
  input  logic              hostCsN,
  input  logic              hostRdN,
  input  logic              hostWrN,
  input  logic [DATA_W-1:0] hostDataIn,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostDataOe,
  input  logic              localWrEn,
  input  logic [DATA_W-1:0] localWrData,
  input  logic              localRdEn,
  output logic [DATA_W-1:0] localRdData,
  input  logic              irqClr,
  output logic              inFull,
  output logic              outFull,
  output logic              portIrq,
  output logic              overflow
);
  localparam int STROBE_N = 3;

  logic [STROBE_N-1:0] rawStrobes, syncStrobes;
  pbusStrobes_t        ctlStrobes;

  assign rawStrobes = {hostCsN, hostRdN, hostWrN};

  pbus_sync #(.WIDTH(STROBE_N), .STAGES(SYNC_STAGES)) uSync (
    .clk (clk),
    .rstN(rstN),
    .din (rawStrobes),
    .dout(syncStrobes)
  );

  pbus_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .portEnable(portEnable),
    .csSyncN   (syncStrobes[2]),
    .rdSyncN   (syncStrobes[1]),
    .wrSyncN   (syncStrobes[0]),
    .strobes   (ctlStrobes)
  );

  pbus_datapath #(.DATA_W(DATA_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (ctlStrobes),
    .hostDataIn (hostDataIn),
    .hostDataOut(hostDataOut),
    .hostDataOe (hostDataOe),
    .localWrEn  (localWrEn),
    .localWrData(localWrData),
    .localRdEn  (localRdEn),
    .localRdData(localRdData),
    .irqClr     (irqClr),
    .inFull     (inFull),
    .outFull    (outFull),
    .portIrq    (portIrq),
    .overflow   (overflow)
  );
endmodule

// File: rtl/pbus_slave_port_chk.sv
module pbus_slave_port_chk (
  input logic clk,
  input logic rstN,
  input logic portEnable,
  input logic hostDataOe,
  input logic localWrEn,
  input logic localRdEn,
  input logic irqClr,
  input logic inFull,
  input logic outFull,
  input logic portIrq,
  input logic overflow
);
  assert_oe_needs_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
    hostDataOe |-> portEnable);

  assert_infull_raises_irq_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(inFull) |-> portIrq);

  assert_read_end_irq_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(outFull) && !$past(localRdEn)) |-> portIrq);

  assert_outfull_on_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    localWrEn |=> outFull);

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  assert_irq_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (portIrq && !irqClr) |=> portIrq);
endmodule

bind pbus_slave_port pbus_slave_port_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .portEnable(portEnable),
  .hostDataOe(hostDataOe),
  .localWrEn (localWrEn),
  .localRdEn (localRdEn),
  .irqClr    (irqClr),
  .inFull    (inFull),
  .outFull   (outFull),
  .portIrq   (portIrq),
  .overflow  (overflow)
);

// File: tb/tb_pbus_slave_port.sv
module tb_pbus_slave_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       portEnable = 1'b0;
  logic       hostCsN = 1'b1, hostRdN = 1'b1, hostWrN = 1'b1;
  logic [7:0] hostDataIn = 8'h00;
  logic [7:0] hostDataOut;
  logic       hostDataOe;
  logic       localWrEn = 1'b0, localRdEn = 1'b0, irqClr = 1'b0;
  logic [7:0] localWrData = 8'h00;
  logic [7:0] localRdData;
  logic       inFull, outFull, portIrq, overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  pbus_slave_port dut (
    .clk(clk), .rstN(rstN), .portEnable(portEnable),
    .hostCsN(hostCsN), .hostRdN(hostRdN), .hostWrN(hostWrN),
    .hostDataIn(hostDataIn), .hostDataOut(hostDataOut), .hostDataOe(hostDataOe),
    .localWrEn(localWrEn), .localWrData(localWrData),
    .localRdEn(localRdEn), .localRdData(localRdData),
    .irqClr(irqClr), .inFull(inFull), .outFull(outFull),
    .portIrq(portIrq), .overflow(overflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [7:0] d);
    hostDataIn = d; hostCsN = 1'b0; hostWrN = 1'b0;
    idle(6);
    hostWrN = 1'b1; hostCsN = 1'b1;
    idle(6);
    hostDataIn = 8'h00;
  endtask

  task automatic localWrite(input logic [7:0] d);
    localWrData = d; localWrEn = 1'b1; idle(1); localWrEn = 1'b0; idle(1);
  endtask

  task automatic localRead();
    localRdEn = 1'b1; idle(1); localRdEn = 1'b0; idle(1);
  endtask

  task automatic clearIrq();
    irqClr = 1'b1; idle(1); irqClr = 1'b0; idle(1);
  endtask

  task automatic testReset();
    chk("R1 inFull", inFull, 0);
    chk("R1 outFull", outFull, 0);
    chk("R1 portIrq", portIrq, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 hostDataOe", hostDataOe, 0);
  endtask

  task automatic testDisabled();
    portEnable = 1'b0;
    hostWrite(8'h5A);
    chk("R2 inFull after write", inFull, 0);
    chk("R2 portIrq after write", portIrq, 0);
    chk("R2 captured byte", localRdData, 8'h00);
    hostCsN = 1'b0; hostRdN = 1'b0; idle(6);
    chk("R2 no drive", hostDataOe, 0);
    hostCsN = 1'b1; hostRdN = 1'b1; idle(6);
    chk("R2 portIrq after read", portIrq, 0);
  endtask

  task automatic testWrite();
    portEnable = 1'b1; idle(2);
    hostWrite(8'hA5);
    chk("R3 inFull", inFull, 1);
    chk("R3 portIrq", portIrq, 1);
    chk("R3 captured byte", localRdData, 8'hA5);
    chk("R8 no overflow", overflow, 0);
    idle(10);
    chk("R9 irq held", portIrq, 1);
    clearIrq();
    chk("R9 irq cleared", portIrq, 0);
    localRead();
    chk("R7 inFull cleared", inFull, 0);
    chk("R7 byte kept", localRdData, 8'hA5);
  endtask

  task automatic testOverflow();
    hostWrite(8'h11);
    chk("R8 still clear", overflow, 0);
    hostWrite(8'h22);
    chk("R8 overflow set", overflow, 1);
    chk("R8 newer byte", localRdData, 8'h22);
    localRead();
    chk("R8 sticky after read", overflow, 1);
    chk("R7 inFull cleared", inFull, 0);
    clearIrq();
  endtask

  task automatic testRead();
    localWrite(8'hC3);
    chk("R6 outFull", outFull, 1);
    hostCsN = 1'b0; hostRdN = 1'b0; idle(6);
    chk("R4 drive", hostDataOe, 1);
    chk("R4 data", hostDataOut, 8'hC3);
    chk("R4 outFull during read", outFull, 1);
    hostRdN = 1'b1; hostCsN = 1'b1; idle(6);
    chk("R5 release", hostDataOe, 0);
    chk("R5 portIrq", portIrq, 1);
    chk("R5 outFull cleared", outFull, 0);
    clearIrq();
  endtask

  task automatic testInvalid();
    localWrite(8'h3C);
    hostDataIn = 8'h99;
    hostCsN = 1'b0; hostRdN = 1'b0; hostWrN = 1'b0; idle(6);
    chk("R10 no drive", hostDataOe, 0);
    hostCsN = 1'b1; hostRdN = 1'b1; hostWrN = 1'b1; idle(6);
    chk("R10 portIrq", portIrq, 0);
    chk("R10 inFull", inFull, 0);
    chk("R10 outFull", outFull, 1);
    chk("R10 byte", localRdData, 8'h22);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    testReset();
    testDisabled();
    testWrite();
    testOverflow();
    testRead();
    testInvalid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule